// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block sits beside the instruction fetch unit and tells it where to fetch next. It holds a small, fully associative set of entries. Each valid entry stores the complete address of a branch instruction, the address that branch last jumped to, and a two-bit saturating direction counter. In every cycle the current fetch address is compared with all stored branch addresses at once. If an entry matches and its counter predicts taken, the stored target becomes the next fetch address. Otherwise the fetch unit proceeds sequentially.

When the back end resolves a branch, it presents the branch address, its real direction and its real target. If an entry already holds that branch, the entry's counter moves one step toward the real direction. A taken outcome also rewrites the stored target. If no entry holds the branch, a new entry is created only when the branch went taken. A branch that never goes taken therefore never uses a slot. Allocation fills empty slots first. Once every slot is full, a rotating pointer picks the slot to replace.

Top module: `fetch_target_buffer`

## Requirements
- R1: After synchronous reset every entry is empty, so no fetch address hits until a taken branch has been resolved.
- R2: When the fetch address matches no valid entry, `pred_hit` and `pred_taken` are 0 and `next_pc` equals the fetch address plus 4.
- R3: When the fetch address matches an entry whose counter has bit 1 set (binary 10 or 11), `pred_hit` and `pred_taken` are 1 and `next_pc` is the stored target.
- R4: When the fetch address matches an entry whose counter has bit 1 clear (binary 00 or 01), `pred_hit` is 1, `pred_taken` is 0 and `next_pc` is the fetch address plus 4.
- R5: A branch that resolves taken and is not stored gets an entry that holds its address and target. The entry's counter starts at binary 11, so a single later not-taken outcome still leaves it predicting taken.
- R6: A branch that resolves not taken and is not stored creates no entry.
- R7: A resolved outcome on a stored branch moves its counter by one: up for taken, down for not taken. The counter saturates at 11 and at 00.
- R8: A taken outcome on a stored branch replaces its target with the newly resolved target. A not-taken outcome leaves the target unchanged.
- R9: Allocation uses the lowest-numbered empty slot. When no slot is empty, it replaces the slot named by a rotating pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, after each replacement. With the table filled in order, the oldest branch is evicted first, then the next oldest.
- R10: A resolve writes the table at the clock edge. A fetch lookup in the same cycle sees the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| pred_hit | output | 1 | Fetch address matches a stored branch |
| pred_taken | output | 1 | Matching entry predicts taken |
| next_pc | output | ADDR_W | Predicted next fetch address |
| resolve_valid | input | 1 | A branch outcome is presented this cycle |
| resolve_pc | input | ADDR_W | Address of the resolved branch |
| resolve_taken | input | 1 | Real direction of the resolved branch |
| resolve_target | input | ADDR_W | Real target of the resolved branch |

## Verification
The checker verifies on every cycle that the outputs are consistent with one another: sequential flow on a miss or on a not-taken hit, and no taken prediction without a hit. It also checks that the table is empty right after reset and that a taken resolution is visible to a lookup in the following cycle. Three behaviours depend on a stored history that a single-cycle property cannot follow: the counter's exact path and its saturation at both ends, the rewriting of the target, and the order in which victims are replaced. The bench's directed sequences show these.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_ALLOC = 2'b11;
  localparam int   PC_STEP   = 4;

  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == 2'b11) ? c : c + 2'd1;
    else       r = (c == 2'b00) ? c : c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/ftb_cam.sv
module ftb_cam #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [ADDR_W-1:0]  tags [ENTRIES],
  input  logic [ADDR_W-1:0]  key,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);

  logic [ENTRIES-1:0] match;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = valid[g] && (tags[g] == key);
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/ftb_victim.sv
module ftb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid,
  input  logic               alloc,
  output logic [IDX_W-1:0]   slot
);

  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_q;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_free = ~&valid;
  assign slot     = any_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (alloc && !any_free) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/fetch_target_buffer.sv
module fetch_target_buffer #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] next_pc,
  input  logic              resolve_valid,
  input  logic [ADDR_W-1:0] resolve_pc,
  input  logic              resolve_taken,
  input  logic [ADDR_W-1:0] resolve_target
);
  import ftb_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  ctr_t               ctr_q [ENTRIES];

  logic             f_hit, r_hit, alloc;
  logic [IDX_W-1:0] f_idx, r_idx, v_slot;
  logic [ADDR_W-1:0] seq_pc;

  ftb_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_fetch_cam (
    .valid(valid_q), .tags(tag_q), .key(fetch_pc), .hit(f_hit), .idx(f_idx)
  );

  ftb_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_resolve_cam (
    .valid(valid_q), .tags(tag_q), .key(resolve_pc), .hit(r_hit), .idx(r_idx)
  );

  assign alloc = resolve_valid && resolve_taken && !r_hit;

  ftb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .valid(valid_q), .alloc(alloc), .slot(v_slot)
  );

  assign seq_pc     = fetch_pc + ADDR_W'(PC_STEP);
  assign pred_hit   = f_hit;
  assign pred_taken = f_hit && ctr_q[f_idx][1];
  assign next_pc    = pred_taken ? tgt_q[f_idx] : seq_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (alloc) begin
      valid_q[v_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && resolve_valid) begin
      if (r_hit) begin
        ctr_q[r_idx] <= ctr_step(ctr_q[r_idx], resolve_taken);
        if (resolve_taken) tgt_q[r_idx] <= resolve_target;
      end else if (resolve_taken) begin
        tag_q[v_slot] <= resolve_pc;
        tgt_q[v_slot] <= resolve_target;
        ctr_q[v_slot] <= CTR_ALLOC;
      end
    end
  end

endmodule

// File: rtl/fetch_target_buffer_chk.sv
module fetch_target_buffer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              pred_hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] next_pc,
  input logic              resolve_valid,
  input logic [ADDR_W-1:0] resolve_pc,
  input logic              resolve_taken
);

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pred_hit); // R1

  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> next_pc == fetch_pc + ADDR_W'(4)); // R2

  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> pred_hit); // R3

  AST_WEAK_HIT_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    (pred_hit && !pred_taken) |-> next_pc == fetch_pc + ADDR_W'(4)); // R4

  AST_TAKEN_RESOLVE_STORED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(resolve_valid && resolve_taken) && fetch_pc == $past(resolve_pc))
      |-> pred_hit); // R5

endmodule

bind fetch_target_buffer fetch_target_buffer_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/fetch_target_buffer_test.sv
module fetch_target_buffer_test;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] fetch_pc = '0;
  logic          pred_hit, pred_taken;
  logic [AW-1:0] next_pc;
  logic          resolve_valid = 1'b0;
  logic [AW-1:0] resolve_pc = '0;
  logic          resolve_taken = 1'b0;
  logic [AW-1:0] resolve_target = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fetch_target_buffer #(.ENTRIES(8), .ADDR_W(AW)) uut (.*);

  // row: rv, rt, rpc, rtgt, fpc, exp_hit, exp_taken, exp_next
  localparam int NV = 18;
  localparam logic [131:0] VEC [NV] = '{
    {1'b1,1'b0,32'h100,32'h0,  32'h100,1'b0,1'b0,32'h104}, // R6 not-taken resolve
    {1'b0,1'b0,32'h0,  32'h0,  32'h100,1'b0,1'b0,32'h104}, // R6 nothing stored
    {1'b1,1'b1,32'h200,32'h800,32'h200,1'b0,1'b0,32'h204}, // R10 same-cycle miss
    {1'b0,1'b0,32'h0,  32'h0,  32'h200,1'b1,1'b1,32'h800}, // R5 R3 allocated 11
    {1'b1,1'b0,32'h200,32'h0,  32'h200,1'b1,1'b1,32'h800}, // R7 11->10
    {1'b0,1'b0,32'h0,  32'h0,  32'h200,1'b1,1'b1,32'h800}, // R5 still taken at 10
    {1'b1,1'b0,32'h200,32'h0,  32'h200,1'b1,1'b1,32'h800}, // R7 10->01
    {1'b0,1'b0,32'h0,  32'h0,  32'h200,1'b1,1'b0,32'h204}, // R4 weak not taken
    {1'b1,1'b0,32'h200,32'h0,  32'h200,1'b1,1'b0,32'h204}, // R7 01->00
    {1'b1,1'b0,32'h200,32'h0,  32'h200,1'b1,1'b0,32'h204}, // R7 00 floor
    {1'b1,1'b1,32'h200,32'h900,32'h200,1'b1,1'b0,32'h204}, // R7 00->01, R8 new tgt
    {1'b0,1'b0,32'h0,  32'h0,  32'h200,1'b1,1'b0,32'h204}, // R7 at 01
    {1'b1,1'b1,32'h200,32'h900,32'h200,1'b1,1'b0,32'h204}, // R7 01->10
    {1'b0,1'b0,32'h0,  32'h0,  32'h200,1'b1,1'b1,32'h900}, // R8 target rewritten
    {1'b1,1'b1,32'h200,32'hA00,32'h200,1'b1,1'b1,32'h900}, // R8 R7 10->11
    {1'b1,1'b1,32'h200,32'hA00,32'h200,1'b1,1'b1,32'hA00}, // R7 11 ceiling
    {1'b1,1'b0,32'h200,32'h0,  32'h200,1'b1,1'b1,32'hA00}, // R7 11->10, R8 keep tgt
    {1'b0,1'b0,32'h0,  32'h0,  32'h200,1'b1,1'b1,32'hA00}  // R7 no wrap at ceiling
  };

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic look(input string req, input logic [AW-1:0] pc,
                      input logic eh, input logic et, input logic [AW-1:0] en);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    chk({req, " hit"},   AW'(pred_hit),   AW'(eh));
    chk({req, " taken"}, AW'(pred_taken), AW'(et));
    chk({req, " next"},  next_pc, en);
  endtask

  task automatic resolve(input logic [AW-1:0] pc, input logic tk, input logic [AW-1:0] tgt);
    @(negedge clk);
    resolve_valid = 1'b1; resolve_pc = pc; resolve_taken = tk; resolve_target = tgt;
    @(negedge clk);
    resolve_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    look("R1 after reset", 32'h100, 1'b0, 1'b0, 32'h104);
    look("R2 miss", 32'hFFFF_FFFC, 1'b0, 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {resolve_valid, resolve_taken, resolve_pc, resolve_target,
       fetch_pc} = VEC[i][131:34];
      #1;
      chk($sformatf("R3/R4/R7 row %0d hit", i),   AW'(pred_hit),   AW'(VEC[i][33]));
      chk($sformatf("R3/R4/R7 row %0d taken", i), AW'(pred_taken), AW'(VEC[i][32]));
      chk($sformatf("R3/R4/R7 row %0d next", i),  next_pc, VEC[i][31:0]);
    end
    @(negedge clk);
    resolve_valid = 1'b0;

    // R9 fill then round-robin replacement
    do_reset();
    for (int i = 0; i < 8; i++) resolve(32'h1000 + 32'(i * 16), 1'b1, 32'h5000 + 32'(i * 16));
    for (int i = 0; i < 8; i++)
      look("R9 filled", 32'h1000 + 32'(i * 16), 1'b1, 1'b1, 32'h5000 + 32'(i * 16));
    resolve(32'h2000, 1'b1, 32'h6000);
    look("R9 first victim gone", 32'h1000, 1'b0, 1'b0, 32'h1004);
    look("R9 second kept",       32'h1010, 1'b1, 1'b1, 32'h5010);
    look("R9 new entry",         32'h2000, 1'b1, 1'b1, 32'h6000);
    resolve(32'h2010, 1'b1, 32'h6010);
    look("R9 second victim gone", 32'h1010, 1'b0, 1'b0, 32'h1014);
    look("R9 third kept",         32'h1020, 1'b1, 1'b1, 32'h5020);
    look("R9 first new kept",     32'h2000, 1'b1, 1'b1, 32'h6000);
    resolve(32'h3000, 1'b0, 32'h7000);
    look("R6 full table not-taken", 32'h3000, 1'b0, 1'b0, 32'h3004);
    look("R6 no eviction",          32'h1020, 1'b1, 1'b1, 32'h5020);

    do_reset();
    look("R1 reset clears", 32'h2000, 1'b0, 1'b0, 32'h2004);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule